// File: doc/BRIEF.md
# Lockable Timing Configuration Register File

This block holds the eleven timing words (counter reloads, pulse widths, loop limits) that a flash program/erase sequencer reads. A serial front-end turns its register-write and register-read requests into single-cycle strobes with a 16-bit address and 16-bit data. The block applies those strobes to the register file and returns read data one cycle later. Every timing word is also driven continuously onto a wide parallel output bus for the sequencer.

A control word at address F004h guards the timing words. Writing the open key 2BC0h to it permits changes to the timing words. Writing the close key 03C0h forbids them again. While the guard is closed, writes to the timing words are dropped silently. Reset closes the guard and reloads every timing word with a default tuned for the fastest supported pump clock. Software that runs a slower clock must therefore reapply its values after each reset. It reads them back to confirm they took.

Top module: `tcfg_regfile`

## Requirements
- R1: In the cycle after `rst` is sampled high, every timing word holds its default and the guard is closed. The defaults are 8006h=0764h, 8008h=307Dh, 8009h=0D0Dh, 800Dh=0D0Dh, 800Eh=01F4h, 8010h=0D0Dh, 8014h=0032h, 8015h=83D6h, 8016h=186Ah, 8017h=0D0Dh and 8018h=0064h.
- R2: A write of 2BC0h to address F004h opens the guard, and a write of 03C0h to F004h closes it. A write of any other value to F004h leaves the guard as it was.
- R3: While the guard is closed, a write to any timing-word address leaves every timing word unchanged.
- R4: While the guard is open, a write to a timing-word address loads `wdata` into that word. The new value appears on `prm_out` in the cycle after the write strobe, and all other words keep their values.
- R5: `rd_valid` is high in the cycle after `rd_en` and low otherwise. In that cycle `rdata` holds the word at the requested address. When a read and a write to the same address share a cycle, the read returns the value from before the write.
- R6: A read of any address that is not a timing word returns 0000h, and this includes F004h. A write to an address that is neither a timing word nor F004h changes nothing.
- R7: `prm_out` carries timing word k in bits [16k+15:16k]. Index k counts the timing-word addresses in ascending order: k=0 is 8006h and k=10 is 8018h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | 16 | Register address for the current strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid with `rd_valid` |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| prm_out | output | 176 | All timing words, word k at bits [16k+15:16k] |

## Verification
The bench attacks the guard from several angles. It writes while closed, sends wrong keys in both guard states, and re-opens after a mid-run reset. A design that decoded only part of the key, or that let a bad key toggle the guard, would either corrupt timing words or refuse a legitimate update. Addresses between mapped words (8007h, 8011h) and the control address itself are read and written. A loose comparator would alias these onto real words, and a readable control word would return non-zero data. A read that shares a cycle with a write to the same word must return the old value, so an implementation that forwarded write data would be caught. A reset after a change must bring back every default and close the guard, so a design that kept user values or left the guard open fails.

// File: rtl/tcfg_pkg.sv
package tcfg_pkg;

    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 16;
    localparam int NUM_PRM = 11;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [NUM_PRM*DATA_W-1:0] prm_vec_t;

    localparam addr_t CTRL_ADDR = 16'hF004;
    localparam word_t KEY_OPEN  = 16'h2BC0;
    localparam word_t KEY_CLOSE = 16'h03C0;

    typedef enum logic {
        LK_CLOSED = 1'b0,
        LK_OPEN   = 1'b1
    } lock_e;

    typedef struct packed {
        logic  wr;
        logic  rd;
        addr_t addr;
        word_t data;
    } req_t;

    // Address of timing word idx, ascending order.
    function automatic addr_t prm_addr(input int idx);
        case (idx)
            0:       return 16'h8006;
            1:       return 16'h8008;
            2:       return 16'h8009;
            3:       return 16'h800D;
            4:       return 16'h800E;
            5:       return 16'h8010;
            6:       return 16'h8014;
            7:       return 16'h8015;
            8:       return 16'h8016;
            9:       return 16'h8017;
            10:      return 16'h8018;
            default: return 16'h0000;
        endcase
    endfunction

    // Reset value of timing word idx.
    function automatic word_t prm_default(input int idx);
        case (idx)
            0:       return 16'h0764;
            1:       return 16'h307D;
            2:       return 16'h0D0D;
            3:       return 16'h0D0D;
            4:       return 16'h01F4;
            5:       return 16'h0D0D;
            6:       return 16'h0032;
            7:       return 16'h83D6;
            8:       return 16'h186A;
            9:       return 16'h0D0D;
            10:      return 16'h0064;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic prm_vec_t prm_default_vec();
        prm_vec_t v;
        v = '0;
        for (int i = 0; i < NUM_PRM; i++) begin
            v[i*DATA_W +: DATA_W] = prm_default(i);
        end
        return v;
    endfunction

    function automatic logic is_prm_addr(input addr_t a);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < NUM_PRM; i++) begin
            if (a == prm_addr(i)) hit = 1'b1;
        end
        return hit;
    endfunction

endpackage

// File: rtl/tcfg_decode.sv
module tcfg_decode
    import tcfg_pkg::*;
(
    input  addr_t              addr,
    output logic [NUM_PRM-1:0] prm_hit,
    output logic               ctrl_hit
);

    for (genvar g = 0; g < NUM_PRM; g++) begin : g_hit
        assign prm_hit[g] = (addr == prm_addr(g));
    end

    assign ctrl_hit = (addr == CTRL_ADDR);

endmodule

// File: rtl/tcfg_lock.sv
module tcfg_lock
    import tcfg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  logic  ctrl_hit,
    input  word_t wdata,
    output lock_e state
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LK_CLOSED;
        end else if (wr_en && ctrl_hit) begin
            if (wdata == KEY_OPEN) begin
                state <= LK_OPEN;
            end else if (wdata == KEY_CLOSE) begin
                state <= LK_CLOSED;
            end
        end
    end

endmodule

// File: rtl/tcfg_bank.sv
module tcfg_bank
    import tcfg_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  word_t                          wdata,
    input  logic [NUM_PRM-1:0]             prm_hit,
    input  lock_e                          state,
    output logic [NUM_PRM-1:0][DATA_W-1:0] prm_q
);

    logic wr_ok;
    assign wr_ok = wr_en && (state == LK_OPEN);

    for (genvar g = 0; g < NUM_PRM; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                prm_q[g] <= prm_default(g);
            end else if (wr_ok && prm_hit[g]) begin
                prm_q[g] <= wdata;
            end
        end
    end

endmodule

// File: rtl/tcfg_rdport.sv
module tcfg_rdport
    import tcfg_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           rd_en,
    input  logic [NUM_PRM-1:0]             prm_hit,
    input  logic [NUM_PRM-1:0][DATA_W-1:0] prm_q,
    output word_t                          rdata,
    output logic                           rd_valid
);

    word_t sel;

    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_PRM; i++) begin
            sel = sel | (prm_q[i] & {DATA_W{prm_hit[i]}});
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rdata    <= '0;
        end else begin
            rd_valid <= rd_en;
            rdata    <= rd_en ? sel : '0;
        end
    end

endmodule

// File: rtl/tcfg_regfile.sv
module tcfg_regfile
    import tcfg_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         rdata,
    output logic                      rd_valid,
    output logic [NUM_PRM*DATA_W-1:0] prm_out
);

    req_t                           req;
    logic [NUM_PRM-1:0]             prm_hit;
    logic                           ctrl_hit;
    lock_e                          lock_state;
    logic [NUM_PRM-1:0][DATA_W-1:0] prm_q;

    assign req = '{wr: wr_en, rd: rd_en, addr: addr, data: wdata};

    tcfg_decode u_decode (
        .addr     (req.addr),
        .prm_hit  (prm_hit),
        .ctrl_hit (ctrl_hit)
    );

    tcfg_lock u_lock (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (req.wr),
        .ctrl_hit (ctrl_hit),
        .wdata    (req.data),
        .state    (lock_state)
    );

    tcfg_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (req.wr),
        .wdata   (req.data),
        .prm_hit (prm_hit),
        .state   (lock_state),
        .prm_q   (prm_q)
    );

    tcfg_rdport u_rdport (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (req.rd),
        .prm_hit  (prm_hit),
        .prm_q    (prm_q),
        .rdata    (rdata),
        .rd_valid (rd_valid)
    );

    assign prm_out = prm_q;

endmodule

// File: rtl/tcfg_regfile_chk.sv
module tcfg_regfile_chk
    import tcfg_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic                      wr_en,
    input logic                      rd_en,
    input logic [ADDR_W-1:0]         addr,
    input logic [DATA_W-1:0]         wdata,
    input logic [DATA_W-1:0]         rdata,
    input logic                      rd_valid,
    input logic [NUM_PRM*DATA_W-1:0] prm_out,
    input lock_e                     lock_state
);

    AST_RST_CLOSES: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> lock_state == LK_CLOSED);                          // R1

    AST_RST_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> prm_out == prm_default_vec());                    // R1

    AST_KEY_OPENS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == CTRL_ADDR && wdata == KEY_OPEN) |=> lock_state == LK_OPEN);   // R2

    AST_KEY_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == CTRL_ADDR && wdata == KEY_CLOSE) |=> lock_state == LK_CLOSED); // R2

    AST_CLOSED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        lock_state == LK_CLOSED |=> $stable(prm_out));                   // R3

    AST_OPEN_LANDS: assert property (@(posedge clk) disable iff (rst)
        (lock_state == LK_OPEN && wr_en && addr == prm_addr(0))
        |=> prm_out[DATA_W-1:0] == $past(wdata));                        // R4

    AST_RD_VALID_ON: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);                                             // R5

    AST_RD_VALID_OFF: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);                                           // R5

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !is_prm_addr(addr)) |=> rdata == '0);                  // R6

endmodule

bind tcfg_regfile tcfg_regfile_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .rd_valid   (rd_valid),
    .prm_out    (prm_out),
    .lock_state (lock_state)
);

// File: tb/tcfg_regfile_tb_top.sv
module tcfg_regfile_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NW = 11;

    localparam logic [15:0] BADDR [NW] = '{16'h8006, 16'h8008, 16'h8009, 16'h800D,
        16'h800E, 16'h8010, 16'h8014, 16'h8015, 16'h8016, 16'h8017, 16'h8018};
    localparam logic [15:0] BDEF [NW] = '{16'h0764, 16'h307D, 16'h0D0D, 16'h0D0D,
        16'h01F4, 16'h0D0D, 16'h0032, 16'h83D6, 16'h186A, 16'h0D0D, 16'h0064};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [15:0]  addr = '0;
    logic [15:0]  wdata = '0;
    logic [15:0]  rdata;
    logic         rd_valid;
    logic [175:0] prm_out;

    logic [15:0] exp_q [NW];
    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tcfg_regfile dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .prm_out(prm_out)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        for (int k = 0; k < NW; k++) begin
            check(req, prm_out[k*16 +: 16], exp_q[k]);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < NW; k++) exp_q[k] = BDEF[k];
    endtask

    task automatic do_wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [15:0] a, output logic [15:0] v, output logic vld);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata; vld = rd_valid;
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    // R1 R7: defaults at reset, layout, guard closed
    task automatic t_reset_defaults();
        logic [15:0] v; logic vld;
        check_outputs("R1/R7 defaults on bus");
        for (int k = 0; k < NW; k++) begin
            do_rd(BADDR[k], v, vld);
            check("R5 read valid", {15'd0, vld}, 16'd1);
            check("R1 default readback", v, BDEF[k]);
        end
        do_wr(16'h8006, 16'hDEAD);
        check_outputs("R1 guard closed after reset");
        @(negedge clk);
        check("R5 valid low when idle", {15'd0, rd_valid}, 16'd0);
    endtask

    // R3: closed guard drops writes
    task automatic t_locked_writes();
        do_wr(16'h8015, 16'h1111);
        do_wr(16'h8018, 16'h2222);
        do_wr(16'h800D, 16'h3333);
        check_outputs("R3 closed writes dropped");
    endtask

    // R4 R5: open guard, write and read back
    task automatic t_open_write();
        logic [15:0] v; logic vld;
        do_wr(16'hF004, 16'h2BC0);
        do_wr(16'h8015, 16'hA5A5); exp_q[7] = 16'hA5A5;
        check_outputs("R4 single word updated");
        do_wr(16'h8006, 16'h0001); exp_q[0] = 16'h0001;
        do_wr(16'h8018, 16'hFFFF); exp_q[10] = 16'hFFFF;
        check_outputs("R4 boundary words updated");
        do_rd(16'h8015, v, vld);
        check("R5 readback after write", v, 16'hA5A5);
    endtask

    // R2: wrong keys in both guard states
    task automatic t_keys();
        do_wr(16'hF004, 16'h1234);
        do_wr(16'h8018, 16'h0777); exp_q[10] = 16'h0777;
        check_outputs("R2 bad key keeps guard open");
        do_wr(16'hF004, 16'h03C0);
        do_wr(16'h8018, 16'h1111);
        check_outputs("R2 close key closes guard");
        do_wr(16'hF004, 16'h2BC1);
        do_wr(16'h8009, 16'h4444);
        check_outputs("R2 near-miss key keeps guard closed");
    endtask

    // R6: unmapped addresses
    task automatic t_unmapped();
        logic [15:0] v; logic vld;
        do_wr(16'hF004, 16'h2BC0);
        do_wr(16'h8007, 16'hFFFF);
        do_wr(16'h8011, 16'hFFFF);
        do_wr(16'h0006, 16'hFFFF);
        check_outputs("R6 unmapped writes ignored");
        do_rd(16'h8007, v, vld);
        check("R6 unmapped read zero", v, 16'h0000);
        do_rd(16'hF004, v, vld);
        check("R6 control read zero", v, 16'h0000);
        check("R6 read still valid", {15'd0, vld}, 16'd1);
    endtask

    // R5 R4: read and write to one word in one cycle
    task automatic t_same_cycle();
        logic [15:0] v;
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b1; addr = 16'h800E; wdata = 16'h4242;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        v = rdata;
        check("R5 read returns old value", v, exp_q[4]);
        exp_q[4] = 16'h4242;
        check_outputs("R4 same-cycle write landed");
        do_wr(16'hF004, 16'h03C0);
    endtask

    // R1: reset after changes
    task automatic t_reset_mid();
        do_wr(16'hF004, 16'h2BC0);
        do_wr(16'h8010, 16'h9999); exp_q[5] = 16'h9999;
        check_outputs("R4 pre-reset write");
        pulse_reset();
        check_outputs("R1 defaults restored");
        do_wr(16'h8010, 16'h0001);
        check_outputs("R1 guard closed after second reset");
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_defaults();
        t_locked_writes();
        t_open_write();
        t_keys();
        t_unmapped();
        t_same_cycle();
        t_reset_mid();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule